// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit

This block performs unsigned multiplication and division for a 12-bit accumulator datapath. It holds no architectural state of its own: the caller hands in the current accumulator word (AC), the multiplier-quotient word (MQ) and a 12-bit operand, picks an operation, and gets back the new AC, MQ and Link. A multiply takes MQ times the operand and returns the 24-bit product split across AC (high half) and MQ (low half). A divide treats AC:MQ as a 24-bit dividend and returns the quotient in MQ and the remainder in AC.

The work is iterative, one bit per clock. A divide whose dividend is zero, or whose divisor does not exceed the high (AC) half of the dividend, is not carried out. The unit flags it by setting the Link and finishes after a single step. Signed arithmetic is left to software.

Requests use a valid/ready handshake. `in_ready` is high only while the unit is idle, and a request transfers on a clock edge where `in_valid` and `in_ready` are both high. A request offered while `in_ready` is low is not held or queued: it is dropped and has no effect. The result side has no back-pressure. `res_valid` pulses for one cycle when new results appear on `ac_out`, `mq_out` and `link_out`, and those outputs keep their values until the next result.

Top module: `muldiv_seq`

## Requirements
- R1: After reset, `ac_out`, `mq_out` and `link_out` are 0, `res_valid` is 0 and `in_ready` is 1.
- R2: With `in_op`=0 (multiply), the result is the unsigned 24-bit product `in_mq` × `in_opnd`, with bits 23..12 on `ac_out` and bits 11..0 on `mq_out`; `in_ac` has no effect on it.
- R3: A multiply always returns `link_out`=0.
- R4: With `in_op`=1 (divide), `in_opnd` > `in_ac` and a nonzero dividend, the result has the quotient of {`in_ac`,`in_mq`} / `in_opnd` on `mq_out`, the remainder on `ac_out`, and `link_out`=0.
- R5: A divide with `in_opnd` ≤ `in_ac` (this includes a zero divisor) is an overflow: `link_out`=1, `ac_out`=`in_ac` and `mq_out`=`in_mq`.
- R6: A divide with `in_ac`=0 and `in_mq`=0 is an overflow with the same outputs as R5.
- R7: `res_valid` first rises 13 clock edges after the accepting edge for a multiply or a completed divide, and 1 edge after it for an overflowed divide. It stays high for exactly one cycle.
- R8: `in_ready` is low from the edge after acceptance until the result is delivered. A request offered while `in_ready` is low does not change the result in progress.
- R9: `ac_out`, `mq_out` and `link_out` change only in a cycle where `res_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit idle and able to accept a request |
| in_op | input | 1 | 0 = multiply, 1 = divide |
| in_ac | input | 12 | Current accumulator word (dividend high half) |
| in_mq | input | 12 | Current MQ word (multiplier or dividend low half) |
| in_opnd | input | 12 | Multiplicand or divisor |
| res_valid | output | 1 | One-cycle pulse: new results on the outputs |
| ac_out | output | 12 | Product high half or remainder |
| mq_out | output | 12 | Product low half or quotient |
| link_out | output | 1 | Divide overflow flag |

## Verification
A multiply or a completed divide delivers its results 13 edges after the accepting edge, and an overflowed divide delivers 1 edge after it; all three outputs change together with the `res_valid` pulse. The bench drives requests at falling edges and counts the falling edges after acceptance until it sees `res_valid`. It compares that count with 13 or 1, and only at that point compares the outputs with values it computes itself. At every falling edge before the result, it checks that `in_ready` is low and that the outputs still hold the previous result, and in some runs it offers a conflicting request partway through.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;
endpackage

// File: rtl/md_mul_step.sv
// One shift-and-add iteration: add the operand when the low MQ bit is set,
// then shift the carry/AC/MQ chain right by one place.
module md_mul_step #(
  parameter int W = 12
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mq_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] mq_o
);
  logic [W:0] sum;

  always_comb begin
    sum   = {1'b0, acc_i} + (mq_i[0] ? {1'b0, opnd_i} : {(W+1){1'b0}});
    acc_o = sum[W:1];
    mq_o  = {sum[0], mq_i[W-1:1]};
  end
endmodule

// File: rtl/md_div_step.sv
// One restoring iteration: shift AC:MQ left, trial-subtract the divisor
// from the widened partial remainder, and shift the quotient bit into MQ.
module md_div_step #(
  parameter int W = 12
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mq_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] mq_o
);
  logic [W:0] part;
  logic [W:0] dvsr;
  logic       fits;

  always_comb begin
    part  = {acc_i, mq_i[W-1]};
    dvsr  = {1'b0, opnd_i};
    fits  = (part >= dvsr);
    acc_o = fits ? W'(part - dvsr) : part[W-1:0];
    mq_o  = {mq_i[W-2:0], fits};
  end
endmodule

// File: rtl/md_ctrl.sv
// Sequencer: idle -> run (W iterations) -> finish, or idle -> finish directly
// when the request is an overflowed divide.
module md_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic skip_i,
  output logic idle_o,
  output logic step_o,
  output logic fin_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] ITER = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(1);

  md_state_e      state_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_i) begin
          state_q <= skip_i ? ST_FIN : ST_RUN;
          cnt_q   <= ITER;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - LAST;
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign step_o = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_op,
  input  logic [W-1:0] in_ac,
  input  logic [W-1:0] in_mq,
  input  logic [W-1:0] in_opnd,
  output logic         res_valid,
  output logic [W-1:0] ac_out,
  output logic [W-1:0] mq_out,
  output logic         link_out
);
  logic         accept, skip, idle, step, fin;
  md_op_e       w_op;
  logic         w_ovf;
  logic [W-1:0] w_acc, w_mq, w_opnd;
  logic [W-1:0] m_acc, m_mq, d_acc, d_mq;

  assign in_ready = idle;
  assign accept   = in_valid && idle;
  assign skip     = in_op && ((in_opnd <= in_ac) || ((in_ac == '0) && (in_mq == '0)));

  md_ctrl #(.W(W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .skip_i   (skip),
    .idle_o   (idle),
    .step_o   (step),
    .fin_o    (fin)
  );

  md_mul_step #(.W(W)) mul_i (
    .acc_i (w_acc), .mq_i (w_mq), .opnd_i (w_opnd),
    .acc_o (m_acc), .mq_o (m_mq)
  );

  md_div_step #(.W(W)) div_i (
    .acc_i (w_acc), .mq_i (w_mq), .opnd_i (w_opnd),
    .acc_o (d_acc), .mq_o (d_mq)
  );

  // working registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_op   <= OP_MUL;
      w_ovf  <= 1'b0;
      w_acc  <= '0;
      w_mq   <= '0;
      w_opnd <= '0;
    end else if (accept) begin
      w_op   <= md_op_e'(in_op);
      w_ovf  <= skip;
      w_acc  <= in_op ? in_ac : '0;
      w_mq   <= in_mq;
      w_opnd <= in_opnd;
    end else if (step) begin
      w_acc <= (w_op == OP_DIV) ? d_acc : m_acc;
      w_mq  <= (w_op == OP_DIV) ? d_mq  : m_mq;
    end
  end

  // visible results, written only at completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_out    <= '0;
      mq_out    <= '0;
      link_out  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= fin;
      if (fin) begin
        ac_out   <= w_acc;
        mq_out   <= w_mq;
        link_out <= w_ovf;
      end
    end
  end
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_op,
  input logic [W-1:0] in_ac,
  input logic [W-1:0] in_mq,
  input logic [W-1:0] in_opnd,
  input logic         res_valid,
  input logic [W-1:0] ac_out,
  input logic [W-1:0] mq_out,
  input logic         link_out
);
  localparam int SW = $clog2(W + 3);

  logic           c_busy, c_op, c_ovf;
  logic [W-1:0]   c_ac, c_mq, c_opnd;
  logic [SW-1:0]  c_age;
  logic [2*W-1:0] c_prod, c_back, c_divd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_busy <= 1'b0; c_op <= 1'b0; c_ovf <= 1'b0;
      c_ac <= '0; c_mq <= '0; c_opnd <= '0; c_age <= '0;
    end else if (in_valid && in_ready) begin
      c_busy <= 1'b1; c_age <= '0; c_op <= in_op;
      c_ac <= in_ac; c_mq <= in_mq; c_opnd <= in_opnd;
      c_ovf <= in_op && ((in_opnd <= in_ac) || ({in_ac, in_mq} == '0));
    end else if (res_valid) begin
      c_busy <= 1'b0;
    end else if (c_busy) begin
      c_age <= c_age + SW'(1);
    end
  end

  always_comb begin
    c_prod = {{W{1'b0}}, c_mq} * {{W{1'b0}}, c_opnd};
    c_back = {{W{1'b0}}, mq_out} * {{W{1'b0}}, c_opnd} + {{W{1'b0}}, ac_out};
    c_divd = {c_ac, c_mq};
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !res_valid && !link_out); // R1
  AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !c_op) |-> ({ac_out, mq_out} == c_prod)); // R2
  AST_MUL_LINK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !c_op) |-> !link_out); // R3
  AST_DIV_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && c_op && !c_ovf) |-> (!link_out && ac_out < c_opnd && c_back == c_divd)); // R4
  AST_DIV_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && c_ovf) |-> (link_out && ac_out == c_ac && mq_out == c_mq)); // R5
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (c_busy && c_age == (c_ovf ? SW'(1) : SW'(W + 1)))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R8
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(ac_out) && $stable(mq_out) && $stable(link_out))); // R9
endmodule

bind muldiv_seq muldiv_seq_chk #(.W(W)) chk_i (.*);

// File: tb/muldiv_seq_tb_top.sv
module muldiv_seq_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_op = 1'b0;
  logic [W-1:0] in_ac = '0, in_mq = '0, in_opnd = '0;
  logic         in_ready, res_valid, link_out;
  logic [W-1:0] ac_out, mq_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  muldiv_seq #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_ac(in_ac), .in_mq(in_mq), .in_opnd(in_opnd),
    .res_valid(res_valid), .ac_out(ac_out), .mq_out(mq_out), .link_out(link_out)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected results, R2..R6
  function automatic logic [2*W:0] model(input logic op, input logic [W-1:0] a,
                                         input logic [W-1:0] q, input logic [W-1:0] d);
    logic [2*W-1:0] num;
    num = {a, q};
    if (!op) return {1'b0, 24'(q * 24'(d))};
    if (d <= a || num == 0) return {1'b1, a, q};
    return {1'b0, W'(num % d), W'(num / d)};
  endfunction

  task automatic run_op(input logic op, input logic [W-1:0] a, input logic [W-1:0] q,
                        input logic [W-1:0] d, input bit poke);
    logic [2*W:0] exp;
    logic [W-1:0] pa, pq;
    logic pl;
    int n;
    string rq;
    exp = model(op, a, q, d);
    rq  = op ? (exp[2*W] ? ((a == 0 && q == 0) ? "R6" : "R5") : "R4") : "R2";
    @(negedge clk);
    check("R8", "ready when idle", in_ready, 1);
    pa = ac_out; pq = mq_out; pl = link_out;
    in_valid = 1; in_op = op; in_ac = a; in_mq = q; in_opnd = d;
    @(negedge clk);
    in_valid = 0;
    n = 0;
    while (!res_valid && n < 40) begin
      check("R8", "busy not ready", in_ready, 0);
      check("R9", "held during run", {pl, pa, pq}, {link_out, ac_out, mq_out});
      if (poke && n == 3) begin
        in_valid = 1; in_op = ~op; in_ac = ~a; in_mq = ~q; in_opnd = d ^ 12'h5a5;
      end
      @(negedge clk);
      in_valid = 0;
      n++;
    end
    check("R7", "latency", n, exp[2*W] ? 1 : W + 1);
    check(rq, "ac_out", ac_out, exp[2*W-1:W]);
    check(rq, "mq_out", mq_out, exp[W-1:0]);
    check(op ? rq : "R3", "link_out", link_out, exp[2*W]);
    pa = ac_out; pq = mq_out; pl = link_out;
    @(negedge clk);
    check("R7", "pulse one cycle", res_valid, 0);
    check("R9", "held after result", {pl, pa, pq}, {link_out, ac_out, mq_out});
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", "res_valid", res_valid, 0);
    check("R1", "outputs", {link_out, ac_out, mq_out}, 0);
    check("R1", "in_ready", in_ready, 1);
    rst_n = 1;
    // directed corners
    run_op(0, 12'h123, 12'hfff, 12'hfff, 0); // R2 max product, AC ignored
    run_op(0, 12'h000, 12'h000, 12'h abc, 0); // R2 zero
    run_op(0, 12'hfff, 12'h001, 12'h001, 1); // R3, R8 poke
    run_op(1, 12'h000, 12'h064, 12'h007, 0); // R4
    run_op(1, 12'hffe, 12'hfff, 12'hfff, 1); // R4 largest quotient
    run_op(1, 12'h010, 12'h000, 12'h010, 0); // R5 equal
    run_op(1, 12'h005, 12'h009, 12'h000, 0); // R5 zero divisor
    run_op(1, 12'h000, 12'h000, 12'h003, 0); // R6 zero dividend
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, q, d;
      logic op;
      op = 1'($urandom);
      q  = W'($urandom);
      d  = W'($urandom);
      a  = W'($urandom);
      if (op && (i % 5 != 0)) a = (d == 0) ? '0 : W'($urandom % d);
      run_op(op, a, q, d, (i % 4) == 1);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule